// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Forwarding Controller

This block is the hazard control for an in-order pipeline of five stages: fetch, decode, operand read, execute and writeback. The fetch stage presents one instruction descriptor per cycle: two source register indices, a destination register index, a multiply flag and a branch flag. The controller tracks the control fields of every instruction that has left fetch. Each cycle it reports, for every stage, whether that stage keeps its contents and whether it receives an empty slot. It also reports, for each execute operand, where that operand is taken from.

It resolves three kinds of conflict. The first is a read of a register that an older instruction has not yet written. The second is a multiply that keeps the execute unit busy for several cycles. The third is a branch whose outcome is not known until the end of its execute cycle. A mode input chooses how read-after-write conflicts are handled. In interlock mode the reader waits in operand read until the writer has retired. In forwarding mode results are bypassed into execute and the reader never waits. Register index 0 is a constant zero: it never creates a dependency.

Top module: `hazard_ctl`

## Requirements
- R1: A synchronous active-high reset empties every tracked stage and clears the multiply busy count. In the first cycle after reset, with nothing fetched, `hold`, `bubble`, `fwd_a` and `fwd_b` are all zero.
- R2: Interlock mode (`fwd_en`=0). An instruction that directly follows its producer stalls in operand read (`hold[2]`=1, `bubble[3]`=1) for exactly two cycles. In this mode `fwd_a` and `fwd_b` are always 0, so operands come from operand read.
- R3: Interlock mode. With one independent instruction between producer and consumer, the consumer stalls for exactly one cycle. It reads its operands in the cycle after the producer's writeback.
- R4: Forwarding mode (`fwd_en`=1) never raises a data stall. In the consumer's execute cycle, a select code of 1 means the result held in writeback is bypassed. A code of 2 means the result retired in the previous cycle is bypassed.
- R5: A source or destination index of 0 never creates a dependency, and neither do differing indices. Both cases give no stall and a select code of 0 in either mode.
- R6: Each execute operand is checked on its own (`fwd_a` for source 1, `fwd_b` for source 2). When both writeback and the retired slot match a source, the younger result in writeback wins (code 1).
- R7: A multiply stays in execute for MUL_CYC consecutive cycles. In each of its first MUL_CYC-1 cycles, `hold[3]`=1 and `bubble[4]`=1, and an independent follower waits in operand read.
- R8: A busy multiply takes priority over a data stall: execute is held and never bubbled in the same cycle. A dependent follower of a multiply in interlock mode waits in operand read for MUL_CYC-1 structural cycles plus two data cycles.
- R9: While a branch sits in decode, operand read or execute, fetch is suspended: `bubble[0]`=1 and the fetch-stage instruction is discarded. Decode receives an empty slot (`bubble[1]`=1) unless operand read is stalled. Fetch resumes in the cycle the branch is in writeback.
- R10: Stage indices are 0 fetch, 1 decode, 2 operand read, 3 execute and 4 writeback. A stall holds the stalled stage and every stage upstream of it. The stage just downstream gets a bubble each stalled cycle, and `hold[4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = forwarding mode, 0 = interlock mode |
| f_vld | input | 1 | Fetch stage holds an instruction |
| f_rs1 | input | RW | Source 1 register index of the fetched instruction |
| f_rs2 | input | RW | Source 2 register index of the fetched instruction |
| f_rd | input | RW | Destination register index (0 = none) |
| f_mul | input | 1 | Fetched instruction is a multiply |
| f_br | input | 1 | Fetched instruction is a branch |
| hold | output | 5 | Per stage: keep contents this cycle |
| bubble | output | 5 | Per stage: receives an empty slot (index 0: fetch suspended, instruction discarded) |
| fwd_a | output | 2 | Execute source 1 select: 0 operand read, 1 writeback result, 2 retired result |
| fwd_b | output | 2 | Execute source 2 select, same coding |

## Verification
A wrong stage valid bit, a wrong register index or a wrong busy count shows up at the ports within one to three cycles. It appears as a stall that is missing or extra, as a misplaced bubble, as a wrong fetch-suspension length, or as a select code in the wrong cycle. Each cycle, the bench compares all four outputs against a behavioural model. For each scenario it also counts stall, bubble and select events and compares those counts with the numbers the requirements give. A fault that only shifts timing therefore still changes a count.

// File: rtl/hazard_ctl.sv
`timescale 1ns/1ps
module hazard_ctl #(
  parameter int RW      = 5,
  parameter int MUL_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_en,
  input  logic          f_vld,
  input  logic [RW-1:0] f_rs1,
  input  logic [RW-1:0] f_rs2,
  input  logic [RW-1:0] f_rd,
  input  logic          f_mul,
  input  logic          f_br,
  output logic [4:0]    hold,
  output logic [4:0]    bubble,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);
  localparam int IW = 3*RW + 2;
  localparam int CW = (MUL_CYC > 1) ? $clog2(MUL_CYC) : 1;
  localparam int SD = 0, SO = 1, SX = 2, SW = 3;

  logic [IW-1:0] ins [4];
  logic          vld [4];
  logic          rv;
  logic [RW-1:0] rrd;
  logic [CW-1:0] cnt;
  logic          stall_x, dhaz, stall_o, blk;

  function automatic logic [RW-1:0] src1(logic [IW-1:0] x); return x[RW-1:0]; endfunction
  function automatic logic [RW-1:0] src2(logic [IW-1:0] x); return x[2*RW-1:RW]; endfunction
  function automatic logic [RW-1:0] dst(logic [IW-1:0] x);  return x[3*RW-1:2*RW]; endfunction
  function automatic logic is_mul(logic [IW-1:0] x); return x[3*RW]; endfunction
  function automatic logic is_br(logic [IW-1:0] x);  return x[3*RW+1]; endfunction

  function automatic logic hit(logic v, logic [RW-1:0] d, logic [RW-1:0] s);
    return v && (d != '0) && (d == s);
  endfunction

  function automatic logic [1:0] pick(logic [RW-1:0] s, logic wv, logic [RW-1:0] wd,
                                      logic pv, logic [RW-1:0] pd);
    if (hit(wv, wd, s)) return 2'd1;
    if (hit(pv, pd, s)) return 2'd2;
    return 2'd0;
  endfunction

  assign stall_x = vld[SX] && is_mul(ins[SX]) && (cnt != '0);
  assign dhaz    = !fwd_en && vld[SO] &&
                   (hit(vld[SX], dst(ins[SX]), src1(ins[SO])) ||
                    hit(vld[SX], dst(ins[SX]), src2(ins[SO])) ||
                    hit(vld[SW], dst(ins[SW]), src1(ins[SO])) ||
                    hit(vld[SW], dst(ins[SW]), src2(ins[SO])));
  assign stall_o = stall_x || dhaz;
  assign blk     = (vld[SD] && is_br(ins[SD])) ||
                   (vld[SO] && is_br(ins[SO])) ||
                   (vld[SX] && is_br(ins[SX]));

  assign hold   = {1'b0, stall_x, stall_o, stall_o, stall_o && !blk};
  assign bubble = {stall_x, stall_o && !stall_x, 1'b0, blk && !stall_o, blk};

  assign fwd_a = (fwd_en && vld[SX]) ?
                 pick(src1(ins[SX]), vld[SW], dst(ins[SW]), rv, rrd) : 2'd0;
  assign fwd_b = (fwd_en && vld[SX]) ?
                 pick(src2(ins[SX]), vld[SW], dst(ins[SW]), rv, rrd) : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) vld[i] <= 1'b0;
      rv  <= 1'b0;
      cnt <= '0;
    end else begin
      rv      <= vld[SW];
      vld[SW] <= vld[SX] && !stall_x;
      if (!stall_x) vld[SX] <= vld[SO] && !stall_o;
      if (!stall_o) begin
        vld[SO] <= vld[SD];
        vld[SD] <= f_vld && !blk;
      end
      if (stall_x)                                       cnt <= cnt - 1'b1;
      else if (!stall_o && vld[SO] && is_mul(ins[SO]))   cnt <= CW'(MUL_CYC - 1);
      else                                               cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    rrd     <= dst(ins[SW]);
    ins[SW] <= ins[SX];
    if (!stall_x) ins[SX] <= ins[SO];
    if (!stall_o) begin
      ins[SO] <= ins[SD];
      ins[SD] <= {f_br, f_mul, f_rd, f_rs2, f_rs1};
    end
  end
endmodule

// File: rtl/hazard_ctl_chk.sv
`timescale 1ns/1ps
module hazard_ctl_chk #(
  parameter int MUL_CYC = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       fwd_en,
  input logic [4:0] hold,
  input logic [4:0] bubble,
  input logic [1:0] fwd_a,
  input logic [1:0] fwd_b
);
  int run;
  always_ff @(posedge clk) begin
    if (rst)          run <= 0;
    else if (hold[3]) run <= run + 1;
    else              run <= 0;
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) $fell(rst) |-> (hold == 5'd0 && bubble == 5'd0 && fwd_a == 2'd0 && fwd_b == 2'd0)); // R1
  AST_INTERLOCK_NO_BYPASS: assert property (@(posedge clk) disable iff (rst) !fwd_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0)); // R2
  AST_FWD_NO_DATA_STALL: assert property (@(posedge clk) disable iff (rst) fwd_en |-> !(hold[2] && !hold[3])); // R4
  AST_MUL_SPAN: assert property (@(posedge clk) disable iff (rst) hold[3] |-> (run < MUL_CYC - 1)); // R7
  AST_BUSY_BEATS_DATA: assert property (@(posedge clk) disable iff (rst) hold[3] |-> (bubble[4] && !bubble[3] && hold[2])); // R8
  AST_DECODE_EMPTY_ON_BRANCH: assert property (@(posedge clk) disable iff (rst) bubble[1] |-> (bubble[0] && !hold[2])); // R9
  AST_EX_BUBBLE_SOURCE: assert property (@(posedge clk) disable iff (rst) bubble[3] |-> (hold[2] && hold[1] && !hold[3])); // R10
endmodule

bind hazard_ctl hazard_ctl_chk #(.MUL_CYC(MUL_CYC)) u_chk (
  .clk(clk), .rst(rst), .fwd_en(fwd_en), .hold(hold), .bubble(bubble),
  .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/test_hazard_ctl.sv
`timescale 1ns/1ps
module test_hazard_ctl;
  localparam int RW = 5;
  localparam int MC = 3;

  typedef struct packed { logic br; logic mul; logic [RW-1:0] rd, rs2, rs1; } ins_t;
  typedef struct { bit v; int rs1; int rs2; int rd; bit mul; bit br; } mst_t;

  logic clk = 0, rst = 1, fwd_en = 0;
  logic f_vld = 0, f_mul = 0, f_br = 0;
  logic [RW-1:0] f_rs1 = '0, f_rs2 = '0, f_rd = '0;
  logic [4:0] hold, bubble;
  logic [1:0] fwd_a, fwd_b;

  hazard_ctl #(.RW(RW), .MUL_CYC(MC)) i_hazard_ctl (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .f_vld(f_vld), .f_rs1(f_rs1), .f_rs2(f_rs2),
    .f_rd(f_rd), .f_mul(f_mul), .f_br(f_br), .hold(hold), .bubble(bubble),
    .fwd_a(fwd_a), .fwd_b(fwd_b));

  always #2.5 clk = ~clk;

  mst_t m [1:5];
  int   mleft;
  ins_t prog [$];
  int   acc [$];
  int   nvec = 0, nfail = 0, cyc = 0;
  bit   done = 0;
  string tag;
  int c_ostall, c_xhold, c_bx, c_bw, c_b0, c_b1, c_fa1, c_fa2, c_fb1, c_fb2, c_mix, c_both, c_h2;
  int acc_cyc [$];

  function automatic ins_t mk(int rs1, int rs2, int rd, bit mul = 0, bit br = 0);
    ins_t x;
    x.rs1 = RW'(rs1); x.rs2 = RW'(rs2); x.rd = RW'(rd); x.mul = mul; x.br = br;
    return x;
  endfunction

  function automatic bit dep(int k, int s);
    return m[k].v && m[k].rd != 0 && m[k].rd == s;
  endfunction

  task automatic check(string req, bit ok, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    c_ostall = 0; c_xhold = 0; c_bx = 0; c_bw = 0; c_b0 = 0; c_b1 = 0;
    c_fa1 = 0; c_fa2 = 0; c_fb1 = 0; c_fb2 = 0; c_mix = 0; c_both = 0; c_h2 = 0;
    acc.delete(); acc_cyc.delete(); cyc = 0;
  endtask

  task automatic model_reset();
    for (int k = 1; k <= 5; k++) m[k] = '{0, 0, 0, 0, 0, 0};
    mleft = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; f_vld = 0;
    prog.delete();
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 0;
    model_reset();
  endtask

  task automatic one_cycle();
    bit sx, so, blk, fv;
    logic [4:0] eh, eb;
    logic [1:0] ea, ebb;
    mst_t e, fin, nv [1:5];
    @(negedge clk);
    fv = prog.size() > 0;
    f_vld = fv;
    if (fv) begin
      f_rs1 = prog[0].rs1; f_rs2 = prog[0].rs2; f_rd = prog[0].rd;
      f_mul = prog[0].mul; f_br = prog[0].br;
    end
    #1;
    sx  = m[3].v && m[3].mul && mleft > 0;
    so  = sx || (!fwd_en && m[2].v &&
          (dep(3, m[2].rs1) || dep(3, m[2].rs2) || dep(4, m[2].rs1) || dep(4, m[2].rs2)));
    blk = (m[1].v && m[1].br) || (m[2].v && m[2].br) || (m[3].v && m[3].br);
    eh  = {1'b0, sx, so, so, so && !blk};
    eb  = {sx, so && !sx, 1'b0, blk && !so, blk};
    ea  = 2'd0; ebb = 2'd0;
    if (fwd_en && m[3].v) begin
      ea  = dep(4, m[3].rs1) ? 2'd1 : dep(5, m[3].rs1) ? 2'd2 : 2'd0;
      ebb = dep(4, m[3].rs2) ? 2'd1 : dep(5, m[3].rs2) ? 2'd2 : 2'd0;
    end
    nvec++;
    if ({hold, bubble, fwd_a, fwd_b} !== {eh, eb, ea, ebb}) begin
      nfail++;
      $display("FAIL %s cycle %0d: actual hold=%b bubble=%b fa=%0d fb=%0d expected hold=%b bubble=%b fa=%0d fb=%0d",
               tag, cyc, hold, bubble, fwd_a, fwd_b, eh, eb, ea, ebb);
    end
    if (hold[2] && !hold[3]) c_ostall++;
    if (hold[2]) c_h2++;
    if (hold[3]) c_xhold++;
    if (bubble[3]) c_bx++;
    if (bubble[4]) c_bw++;
    if (bubble[0]) c_b0++;
    if (bubble[1]) c_b1++;
    if (hold[3] && bubble[3]) c_both++;
    if (fwd_a == 2'd1) c_fa1++;
    if (fwd_a == 2'd2) c_fa2++;
    if (fwd_b == 2'd1) c_fb1++;
    if (fwd_b == 2'd2) c_fb2++;
    if (fwd_a == 2'd2 && fwd_b == 2'd1) c_mix++;
    e = '{0, 0, 0, 0, 0, 0};
    fin = '{1, int'(f_rs1), int'(f_rs2), int'(f_rd), f_mul, f_br};
    nv[5] = m[4];
    nv[4] = sx ? e : m[3];
    nv[3] = sx ? m[3] : (so ? e : m[2]);
    nv[2] = so ? m[2] : m[1];
    nv[1] = so ? m[1] : ((blk || !fv) ? e : fin);
    if (sx) mleft--;
    else if (!so && m[2].v && m[2].mul) mleft = MC - 1;
    else mleft = 0;
    for (int k = 1; k <= 5; k++) m[k] = nv[k];
    if (fv && !hold[0]) begin
      if (!bubble[0]) begin acc.push_back(int'(prog[0].rd)); acc_cyc.push_back(cyc); end
      void'(prog.pop_front());
    end
    cyc++;
  endtask

  task automatic scenario(string t, bit fm);
    tag = t; fwd_en = fm;
    do_reset();
    clear_counts();
  endtask

  task automatic run(int n);
    repeat (n) one_cycle();
  endtask

  initial begin
    model_reset();
    // R1: reset state
    scenario("R1", 0);
    #1;
    check("R1", hold == 0 && bubble == 0 && fwd_a == 0 && fwd_b == 0, "outputs after reset", {hold, bubble}, 0);
    run(2);

    // R2: back-to-back dependence, interlock
    scenario("R2", 0);
    prog.push_back(mk(0, 0, 1)); prog.push_back(mk(1, 0, 2));
    run(12);
    check("R2", c_ostall == 2, "operand-read stall cycles", c_ostall, 2);
    check("R10", c_bx == 2, "execute bubbles", c_bx, 2);
    check("R2", c_fa1 + c_fa2 + c_fb1 + c_fb2 == 0, "bypass selects in interlock", c_fa1 + c_fa2, 0);

    // R3: distance two, interlock
    scenario("R3", 0);
    prog.push_back(mk(0, 0, 3)); prog.push_back(mk(0, 0, 0)); prog.push_back(mk(0, 3, 4));
    run(12);
    check("R3", c_ostall == 1, "stall cycles at distance two", c_ostall, 1);

    // R4: forwarding mode
    scenario("R4", 1);
    prog.push_back(mk(0, 0, 1)); prog.push_back(mk(1, 0, 4)); prog.push_back(mk(0, 1, 5));
    run(12);
    check("R4", c_ostall == 0, "data stalls in forwarding mode", c_ostall, 0);
    check("R4", c_fa1 == 1, "source 1 bypass from writeback", c_fa1, 1);
    check("R4", c_fb2 == 1, "source 2 bypass from retired", c_fb2, 1);

    // R5: register zero and mismatched indices, both modes
    scenario("R5", 0);
    prog.push_back(mk(0, 0, 0)); prog.push_back(mk(0, 0, 7)); prog.push_back(mk(6, 0, 2));
    prog.push_back(mk(0, 0, 0)); prog.push_back(mk(0, 0, 8));
    run(14);
    check("R5", c_h2 == 0, "stalls without a true dependency", c_h2, 0);
    scenario("R5", 1);
    prog.push_back(mk(0, 0, 0)); prog.push_back(mk(0, 0, 7)); prog.push_back(mk(6, 3, 2));
    run(12);
    check("R5", c_fa1 + c_fa2 + c_fb1 + c_fb2 == 0, "bypass selects without match", c_fa1 + c_fa2 + c_fb1 + c_fb2, 0);

    // R6: independent operands and youngest producer wins
    scenario("R6", 1);
    prog.push_back(mk(0, 0, 5)); prog.push_back(mk(0, 0, 6)); prog.push_back(mk(5, 6, 9));
    run(12);
    check("R6", c_mix == 1, "source1=retired with source2=writeback", c_mix, 1);
    scenario("R6", 1);
    prog.push_back(mk(0, 0, 5)); prog.push_back(mk(0, 0, 5)); prog.push_back(mk(5, 0, 9));
    run(12);
    check("R6", c_fa1 == 1 && c_fa2 == 0, "youngest producer selected", c_fa1 * 10 + c_fa2, 10);

    // R7: multiply occupancy
    scenario("R7", 0);
    prog.push_back(mk(0, 0, 1, 1)); prog.push_back(mk(2, 0, 3));
    run(14);
    check("R7", c_xhold == MC - 1, "execute hold cycles", c_xhold, MC - 1);
    check("R7", c_bw == MC - 1, "writeback bubbles", c_bw, MC - 1);
    check("R7", c_ostall == 0, "data stalls for independent follower", c_ostall, 0);
    scenario("R7", 1);
    prog.push_back(mk(0, 0, 1, 1)); prog.push_back(mk(1, 0, 3));
    run(14);
    check("R7", c_h2 == MC - 1 && c_fa1 == 1, "dependent follower in forwarding mode", c_h2, MC - 1);

    // R8: structural priority over data
    scenario("R8", 0);
    prog.push_back(mk(0, 0, 1, 1)); prog.push_back(mk(1, 0, 3));
    run(16);
    check("R8", c_h2 == MC + 1, "total operand-read hold cycles", c_h2, MC + 1);
    check("R8", c_both == 0, "execute held and bubbled together", c_both, 0);
    check("R8", c_ostall == 2, "data-only stall cycles", c_ostall, 2);

    // R9: branch suspends fetch
    scenario("R9", 0);
    prog.push_back(mk(0, 0, 0, 0, 1)); prog.push_back(mk(0, 0, 11)); prog.push_back(mk(0, 0, 12));
    prog.push_back(mk(0, 0, 13)); prog.push_back(mk(0, 0, 14));
    run(14);
    check("R9", c_b0 == 3, "fetch suspended cycles", c_b0, 3);
    check("R9", c_b1 == 3, "decode bubbles", c_b1, 3);
    check("R9", acc.size() == 2, "instructions accepted", acc.size(), 2);
    if (acc.size() == 2) begin
      check("R9", acc[1] == 14, "first instruction after branch", acc[1], 14);
      check("R9", acc_cyc[1] - acc_cyc[0] == 4, "fetch resume gap", acc_cyc[1] - acc_cyc[0], 4);
    end

    // R1: reset in the middle of a stall
    scenario("R1", 0);
    prog.push_back(mk(0, 0, 1, 1)); prog.push_back(mk(1, 0, 3));
    run(3);
    do_reset();
    #1;
    check("R1", hold == 0 && bubble == 0 && fwd_a == 0 && fwd_b == 0, "outputs after mid-run reset", {hold, bubble}, 0);
    run(3);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule